// File: doc/BRIEF.md
# I/O Page Table Translation Unit

This block turns a 32-bit device-side virtual address into a 36-bit physical address. It fetches one entry from a single-level page table held in memory. A requester presents an address and a direction flag on a valid/ready port. Once the request is accepted, the unit works out where the entry for that 4 KB page lives. The entry location depends on a table base value and on the size of the translation window, and both come from a configuration block. The unit issues exactly one 32-bit read for that entry and waits for the word to return. It then checks the word.

A usable entry yields a physical address with either read-only or read-write permission, plus the page address and an offset mask. An entry that is not valid, or one that does not allow a requested write, yields a response with no permission. In that case the unit also sends a one-cycle fault pulse to the error register block, carrying the page address and the direction. Only one translation is in progress at any time.

Top module: `iopt_xlate`

## Requirements
- R1: While reset is applied and in the first cycle after it, `req_ready` is 1 and `mem_rd_valid`, `rsp_valid` and `flt_valid` are 0.
- R2: The entry address is `{cfg_base, 4'b0} + ((page & span) >> 10)`. Here `page` is `req_va` with bits [11:0] cleared, and `span` is 2^(24+`cfg_win`) minus 1 (window code 0 gives a 16 MB window, code 7 a 2 GB window). Address and configuration are taken in the cycle the request is accepted. `mem_rsp_data` is used as one 32-bit word, with bit 31 as its most significant bit.
- R3: After an accepted request, `req_ready` is 0 and `mem_rd_valid` rises in the next cycle. It holds with a stable address until `mem_rd_ready` is seen and then drops, so each translation makes one read.
- R4: If entry bit 1 (valid) is 0, the response has `rsp_perm` = 2'b00, `rsp_pa` = 0, `rsp_iova` = 0 and `rsp_mask` all ones. `flt_valid` pulses with `flt_addr` = page address and `flt_read` = 1 for a read request and 0 for a write.
- R5: A write request to a valid entry with bit 2 (writable) at 0 faults in the same way as R4, with `flt_read` = 0.
- R6: A read request to a valid entry with bit 2 at 0 succeeds with `rsp_perm` = 2'b01 (read-only).
- R7: A successful response has `rsp_pa` = {entry[31:8], va[11:0]}, `rsp_iova` = page address and `rsp_mask` = 0xFFF. `rsp_perm` is 2'b11 (read-write) when bit 2 is set.
- R8: Entry bits 7 and 0 have no effect on any response or fault output.
- R9: `rsp_valid` is a one-cycle pulse in the cycle after `mem_rsp_valid` is seen. `flt_valid` is only ever high together with `rsp_valid`, and the unit then accepts a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_va | input | 32 | Device virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| cfg_base | input | 32 | Page table base, scaled by 16 to form a byte address |
| cfg_win | input | 3 | Window size code, 16 MB << code |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 36 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry word returned |
| mem_rsp_data | input | 32 | Entry word |
| rsp_valid | output | 1 | Translation result pulse |
| rsp_pa | output | 36 | Physical address |
| rsp_iova | output | 32 | Page address of the request |
| rsp_mask | output | 36 | Offset mask |
| rsp_perm | output | 2 | 00 none, 01 read-only, 11 read-write |
| flt_valid | output | 1 | Fault pulse |
| flt_addr | output | 32 | Page address that faulted |
| flt_read | output | 1 | Faulting access was a read |

## Verification
The assertions assume that the memory returns `mem_rsp_valid` only while a read is outstanding, and no earlier than the cycle after the address handshake. They also assume that `mem_rsp_valid` is a single pulse for each read. The bench memory model drives the response only after the grant cycle and only once per read, with random grant and return delays. Random addresses, directions, bases, window codes and entry words are mixed with directed entries at the window edges, for the no-write case and for the ignored entry bits.

// File: rtl/iopt_pkg.sv
package iopt_pkg;
    localparam int VA_W      = 32;
    localparam int PTE_W     = 32;
    localparam int PA_W      = VA_W + 4;
    localparam int PG_SHIFT  = 12;
    localparam int PPN_LSB   = 8;
    localparam int PTE_V_BIT = 1;
    localparam int PTE_W_BIT = 2;

    typedef enum logic [1:0] {
        PERM_NONE = 2'b00,
        PERM_RO   = 2'b01,
        PERM_RW   = 2'b11
    } perm_e;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_ISSUE,
        WS_WAIT,
        WS_RESP
    } walk_st_e;

    typedef struct packed {
        logic              fault;
        perm_e             perm;
        logic [PA_W-1:0]   pa;
        logic [VA_W-1:0]   iova;
        logic [PA_W-1:0]   mask;
    } xlate_res_t;

    function automatic logic [VA_W-1:0] page_of(input logic [VA_W-1:0] a);
        return {a[VA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
    endfunction
endpackage

// File: rtl/iopt_entry_addr.sv
module iopt_entry_addr
    import iopt_pkg::*;
#(
    parameter int WIN_MIN_LOG2 = 24,
    parameter int WIN_CODE_W   = 3
) (
    input  logic [VA_W-1:0]       page,
    input  logic [VA_W-1:0]       base,
    input  logic [WIN_CODE_W-1:0] win,
    output logic [PA_W-1:0]       ent_addr
);
    localparam int NWIN = 1 << WIN_CODE_W;

    logic [VA_W-1:0] span_tab [NWIN];
    logic [VA_W-1:0] idx;

    // One in-window offset mask per window code
    for (genvar g = 0; g < NWIN; g++) begin : g_win
        if (WIN_MIN_LOG2 + g >= VA_W) begin : g_full
            assign span_tab[g] = '1;
        end else begin : g_part
            assign span_tab[g] = VA_W'((64'd1 << (WIN_MIN_LOG2 + g)) - 64'd1);
        end
    end

    // Page index scaled to a word offset; the cleared page bits keep [1:0] zero
    assign idx      = (page & span_tab[win]) >> (PG_SHIFT - 2);
    assign ent_addr = {base, 4'b0000} + {{(PA_W-VA_W){1'b0}}, idx};
endmodule

// File: rtl/iopt_pte_eval.sv
module iopt_pte_eval
    import iopt_pkg::*;
(
    input  logic [PTE_W-1:0] pte,
    input  logic [VA_W-1:0]  va,
    input  logic             wr,
    output xlate_res_t       res
);
    logic entry_ok;
    logic can_write;
    logic unused_pte_bits;

    assign entry_ok        = pte[PTE_V_BIT];
    assign can_write       = pte[PTE_W_BIT];
    assign unused_pte_bits = ^{pte[PPN_LSB-1:PTE_W_BIT+1], pte[PTE_V_BIT-1:0]};

    always_comb begin
        res       = '0;
        res.mask  = '1;
        res.perm  = PERM_NONE;
        if (!entry_ok || (wr && !can_write)) begin
            res.fault = 1'b1;
        end else begin
            res.fault = 1'b0;
            res.perm  = can_write ? PERM_RW : PERM_RO;
            res.pa    = {pte[PTE_W-1:PPN_LSB], va[PG_SHIFT-1:0]};
            res.iova  = page_of(va);
            res.mask  = PA_W'({PG_SHIFT{1'b1}});
        end
    end
endmodule

// File: rtl/iopt_walk_ctrl.sv
module iopt_walk_ctrl
    import iopt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    output logic req_ready,
    output logic accept,
    output logic rd_valid,
    input  logic rd_ready,
    input  logic rsp_in,
    output logic capture,
    output logic out_valid
);
    walk_st_e st, st_nx;

    always_comb begin
        st_nx = st;
        case (st)
            WS_IDLE:  if (req_valid) st_nx = WS_ISSUE;
            WS_ISSUE: if (rd_ready)  st_nx = WS_WAIT;
            WS_WAIT:  if (rsp_in)    st_nx = WS_RESP;
            WS_RESP:                 st_nx = WS_IDLE;
            default:                 st_nx = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= WS_IDLE;
        else     st <= st_nx;
    end

    assign req_ready = (st == WS_IDLE);
    assign accept    = req_valid && req_ready;
    assign rd_valid  = (st == WS_ISSUE);
    assign capture   = (st == WS_WAIT) && rsp_in;
    assign out_valid = (st == WS_RESP);

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !rd_ready |=> rd_valid); // R3
    AST_ONE_READ: assert property (@(posedge clk) disable iff (rst)
        rd_valid && rd_ready |=> !rd_valid); // R3
    AST_OUT_PULSE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid && req_ready); // R9
    AST_OUT_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(rsp_in)); // R9
endmodule

// File: rtl/iopt_xlate.sv
module iopt_xlate
    import iopt_pkg::*;
#(
    parameter int WIN_MIN_LOG2 = 24,
    parameter int WIN_CODE_W   = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [VA_W-1:0]       req_va,
    input  logic                  req_write,
    input  logic [VA_W-1:0]       cfg_base,
    input  logic [WIN_CODE_W-1:0] cfg_win,
    output logic                  mem_rd_valid,
    input  logic                  mem_rd_ready,
    output logic [PA_W-1:0]       mem_rd_addr,
    input  logic                  mem_rsp_valid,
    input  logic [PTE_W-1:0]      mem_rsp_data,
    output logic                  rsp_valid,
    output logic [PA_W-1:0]       rsp_pa,
    output logic [VA_W-1:0]       rsp_iova,
    output logic [PA_W-1:0]       rsp_mask,
    output logic [1:0]            rsp_perm,
    output logic                  flt_valid,
    output logic [VA_W-1:0]       flt_addr,
    output logic                  flt_read
);
    logic            accept;
    logic            capture;
    logic            out_valid;
    logic [PA_W-1:0] ent_addr;
    logic [PA_W-1:0] ent_q;
    logic [VA_W-1:0] va_q;
    logic            wr_q;
    xlate_res_t      res;
    xlate_res_t      res_q;

    iopt_walk_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .accept    (accept),
        .rd_valid  (mem_rd_valid),
        .rd_ready  (mem_rd_ready),
        .rsp_in    (mem_rsp_valid),
        .capture   (capture),
        .out_valid (out_valid)
    );

    iopt_entry_addr #(
        .WIN_MIN_LOG2 (WIN_MIN_LOG2),
        .WIN_CODE_W   (WIN_CODE_W)
    ) u_addr (
        .page     (page_of(req_va)),
        .base     (cfg_base),
        .win      (cfg_win),
        .ent_addr (ent_addr)
    );

    iopt_pte_eval u_eval (
        .pte (mem_rsp_data),
        .va  (va_q),
        .wr  (wr_q),
        .res (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            va_q  <= '0;
            wr_q  <= 1'b0;
            ent_q <= '0;
            res_q <= '0;
        end else begin
            if (accept) begin
                va_q  <= req_va;
                wr_q  <= req_write;
                ent_q <= ent_addr;
            end
            if (capture) begin
                res_q <= res;
            end
        end
    end

    assign mem_rd_addr = ent_q;
    assign rsp_valid   = out_valid;
    assign rsp_pa      = res_q.pa;
    assign rsp_iova    = res_q.iova;
    assign rsp_mask    = res_q.mask;
    assign rsp_perm    = res_q.perm;
    assign flt_valid   = out_valid && res_q.fault;
    assign flt_addr    = page_of(va_q);
    assign flt_read    = !wr_q;

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid && !mem_rd_ready |=> $stable(mem_rd_addr)); // R3
    AST_FAULT_NO_PERM: assert property (@(posedge clk) disable iff (rst)
        flt_valid |-> rsp_perm == PERM_NONE && rsp_pa == '0); // R4
    AST_FLT_WITH_RSP: assert property (@(posedge clk) disable iff (rst)
        flt_valid |-> rsp_valid); // R9
    AST_WRITE_NEEDS_RW: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !flt_valid && !flt_read |-> rsp_perm == PERM_RW); // R5
endmodule

// File: tb/sim_iopt_xlate.sv
module sim_iopt_xlate;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        req_write = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [2:0]  cfg_win = '0;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [35:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic [35:0] rsp_pa;
    logic [31:0] rsp_iova;
    logic [35:0] rsp_mask;
    logic [1:0]  rsp_perm;
    logic        flt_valid;
    logic [31:0] flt_addr;
    logic        flt_read;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    iopt_xlate u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_write(req_write),
        .cfg_base(cfg_base), .cfg_win(cfg_win),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_iova(rsp_iova), .rsp_mask(rsp_mask),
        .rsp_perm(rsp_perm), .flt_valid(flt_valid), .flt_addr(flt_addr), .flt_read(flt_read)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [35:0] exp_ent(input logic [31:0] va, input logic [31:0] base,
                                            input logic [2:0] win);
        logic [63:0] span;
        logic [31:0] off;
        span = (64'd1 << (24 + win)) - 64'd1;
        off  = (va & 32'hFFFF_F000) & span[31:0];
        return {base, 4'b0} + {4'b0, off >> 10};
    endfunction

    function automatic bit exp_fault(input logic [31:0] pte, input logic wr);
        return !pte[1] || (wr && !pte[2]);
    endfunction

    task automatic xlate(input logic [31:0] va, input logic wr, input logic [31:0] base,
                         input logic [2:0] win, input logic [31:0] pte,
                         input int gnt_dly, input int rsp_dly);
        logic [35:0] ea;
        bit          f;
        ea = exp_ent(va, base, win);
        f  = exp_fault(pte, wr);
        @(negedge clk);
        chk(req_ready == 1'b1, "R9", "ready when idle", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_va = va; req_write = wr; cfg_base = base; cfg_win = win;
        @(negedge clk);
        req_valid = 1'b0; req_va = $urandom; req_write = ~wr; cfg_win = 3'($urandom);
        chk(mem_rd_valid == 1'b1, "R3", "read issued", 64'(mem_rd_valid), 64'd1);
        chk(req_ready == 1'b0, "R3", "busy", 64'(req_ready), 64'd0);
        chk(mem_rd_addr == ea, "R2", "entry address", 64'(mem_rd_addr), 64'(ea));
        for (int i = 0; i < gnt_dly; i++) begin
            @(negedge clk);
            chk(mem_rd_valid && mem_rd_addr == ea, "R3", "read held", 64'(mem_rd_addr), 64'(ea));
        end
        mem_rd_ready = 1'b1;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        chk(mem_rd_valid == 1'b0, "R3", "single read", 64'(mem_rd_valid), 64'd0);
        for (int i = 0; i < rsp_dly; i++) begin
            @(negedge clk);
            chk(rsp_valid == 1'b0, "R9", "no early response", 64'(rsp_valid), 64'd0);
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = pte;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = $urandom;
        chk(rsp_valid == 1'b1, "R9", "response pulse", 64'(rsp_valid), 64'd1);
        chk(flt_valid == f, f ? (wr && pte[1] ? "R5" : "R4") : "R7", "fault flag",
            64'(flt_valid), 64'(f));
        if (f) begin
            chk(rsp_perm == 2'b00, "R4", "no permission", 64'(rsp_perm), 64'd0);
            chk(rsp_pa == 36'd0 && rsp_iova == 32'd0, "R4", "zero pa/iova", 64'(rsp_pa), 64'd0);
            chk(rsp_mask == 36'hF_FFFF_FFFF, "R4", "fault mask", 64'(rsp_mask), 64'hF_FFFF_FFFF);
            chk(flt_addr == (va & 32'hFFFF_F000), "R4", "fault page", 64'(flt_addr),
                64'(va & 32'hFFFF_F000));
            chk(flt_read == !wr, wr ? "R5" : "R4", "fault direction", 64'(flt_read), 64'(!wr));
        end else begin
            chk(rsp_perm == (pte[2] ? 2'b11 : 2'b01), pte[2] ? "R7" : "R6", "permission",
                64'(rsp_perm), pte[2] ? 64'd3 : 64'd1);
            chk(rsp_pa == {pte[31:8], va[11:0]}, "R7", "physical address", 64'(rsp_pa),
                64'({pte[31:8], va[11:0]}));
            chk(rsp_iova == (va & 32'hFFFF_F000), "R7", "page address", 64'(rsp_iova),
                64'(va & 32'hFFFF_F000));
            chk(rsp_mask == 36'hFFF, "R7", "offset mask", 64'(rsp_mask), 64'hFFF);
        end
        @(negedge clk);
        chk(rsp_valid == 1'b0 && flt_valid == 1'b0, "R9", "pulse ends",
            64'({rsp_valid, flt_valid}), 64'd0);
        chk(req_ready == 1'b1, "R9", "ready again", 64'(req_ready), 64'd1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        logic [31:0] pte_a;
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "reset ready", 64'(req_ready), 64'd1);
        chk(mem_rd_valid == 1'b0, "R1", "reset read", 64'(mem_rd_valid), 64'd0);
        chk(rsp_valid == 1'b0 && flt_valid == 1'b0, "R1", "reset outputs",
            64'({rsp_valid, flt_valid}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1 && !mem_rd_valid && !rsp_valid, "R1", "after reset",
            64'({req_ready, mem_rd_valid, rsp_valid}), 64'd4);

        // Window edges (R2)
        xlate(32'hFF00_0000, 1'b0, 32'h0001_0000, 3'd0, 32'hABCD_EF06, 0, 0);
        xlate(32'hFFFF_FABC, 1'b1, 32'h0001_0000, 3'd0, 32'h1234_5606, 2, 1);
        xlate(32'h0000_1FFF, 1'b0, 32'h07FF_FC00, 3'd0, 32'h0000_0102, 1, 3);
        xlate(32'h8000_0000, 1'b1, 32'h0000_0400, 3'd7, 32'hFFFF_FF06, 0, 2);
        xlate(32'h7FFF_F123, 1'b0, 32'h0000_0400, 3'd7, 32'h0F0F_0F02, 3, 0);
        // Invalid entry read and write (R4)
        xlate(32'hFE12_3456, 1'b0, 32'h0020_0000, 3'd1, 32'hFFFF_FFFD, 1, 1);
        xlate(32'hFE12_3456, 1'b1, 32'h0020_0000, 3'd1, 32'h0000_0000, 0, 0);
        // Write-protected: write faults (R5), read is read-only (R6)
        xlate(32'hC000_5000, 1'b1, 32'h0300_0000, 3'd6, 32'h5555_5502, 2, 2);
        xlate(32'hC000_5000, 1'b0, 32'h0300_0000, 3'd6, 32'h5555_5502, 0, 1);
        // Bits 7 and 0 ignored (R8)
        pte_a = 32'h9876_5406;
        xlate(32'hF123_4567, 1'b1, 32'h0010_0000, 3'd4, pte_a, 1, 0);
        xlate(32'hF123_4567, 1'b1, 32'h0010_0000, 3'd4, pte_a | 32'h81, 1, 0);
        xlate(32'hF123_4567, 1'b1, 32'h0010_0000, 3'd4, pte_a & ~32'h4 | 32'h81, 0, 0);

        for (int n = 0; n < 200; n++) begin
            logic [31:0] p;
            p = $urandom;
            if ($urandom % 5 != 0) p[1] = 1'b1;
            xlate($urandom, 1'($urandom), $urandom & 32'h07FF_FC00, 3'($urandom), p,
                  int'($urandom % 4), int'($urandom % 4));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule